// File: doc/BRIEF.md
# Raw packet receive deframer

This block sits behind a demodulator and turns a serial bit stream into payload bytes. Each received bit comes with a one-cycle valid strobe. Once armed, the block hunts for a programmable 24-bit frame-sync pattern. The preamble ahead of the pattern needs no special handling, because it simply never matches. After the pattern, the block packs each group of eight bits into a byte and writes it to a receive buffer through a plain write port. The write address starts at zero on every sync hit.

The packet length sits in a register inside the block. The host can write this register at any moment, including in the middle of a packet. The block always compares against the current value, so raising or lowering the length mid-packet moves the end of the frame. An optional trailing CRC of one to four octets follows the payload and is checked against a CRC computed over the payload bits. A packet also ends early when the RSSI-low flag rises (if that option is enabled) or when an abort command arrives.

On every exit the block raises a done pulse and sets three held status bits: CRC match, RSSI termination and command termination. It also writes the number of payload octets actually received into the length register, which the host reads back on `len_o`.

Top module: `raw_rx_deframer`

## Requirements
- R1: After `arm_i`, the payload starts with the first valid bit after a window of 24 consecutive valid bits equal to `sync_word_i`, where bit 23 of the pattern is the earliest bit. Bits that do not complete a matching window start nothing. The allowed number of mismatching bits is the parameter `SYNC_ERRS` (default 0).
- R2: Payload bytes are assembled LSB first. Each byte is written with `wr_en_o` high for one cycle, on the edge that takes its eighth bit. Addresses run 0, 1, 2 and so on from each sync hit.
- R3: The payload ends after N octets, where N is the value the length register holds when the comparison is made. A host write through `len_we_i` during reception that raises N extends the frame to the new value.
- R4: `crc_sel_i` selects the CRC: 0 gives 1 octet with polynomial 0x07, 1 gives 2 octets with 0x1021, 2 gives 3 octets with 0x864CFB, 3 gives 4 octets with 0x04C11DB7. The CRC starts at all ones, is not reflected, has no final XOR, and takes the payload bits in arrival order. The k-th CRC bit received is bit k of the CRC value. A match sets `crc_ok_o`.
- R5: A CRC field that does not match leaves `crc_ok_o` at 0. With `crc_en_i` low, no CRC field is expected, the frame ends right after the last payload byte, and `crc_ok_o` stays 0.
- R6: With `rssi_en_i` high, `rssi_low_i` during payload or CRC reception ends the frame and sets `rssi_abort_o`. With `rssi_en_i` low, `rssi_low_i` has no effect.
- R7: `abort_i` while busy ends the frame on the next edge with `cmd_abort_o` set. This holds during the hunt as well. The abort takes priority over an RSSI drop in the same cycle.
- R8: At the end of every frame, the length register (`len_o`) holds the number of payload octets written. A frame that ends during the CRC field reports the full payload count.
- R9: After reset the block is idle, with `done_o`, `wr_en_o`, `len_o` and all status bits at 0. `done_o` is a single-cycle pulse. The status bits hold until the next arm.
- R10: A length of 0 ends the payload at the sync hit. The CRC field (if enabled) follows at once and equals the initial value.
- R11: A host write that lowers the length below the octets already received ends the frame on the following edge. The reported count is the number of octets already written, and later bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Start hunting for a frame (ignored while busy) |
| bit_i | input | 1 | Demodulated data bit |
| bit_vld_i | input | 1 | Strobe qualifying `bit_i` |
| sync_word_i | input | SYNC_W | Frame-sync pattern, bit SYNC_W-1 first |
| crc_en_i | input | 1 | A CRC field follows the payload |
| crc_sel_i | input | 2 | CRC width and polynomial select |
| rssi_en_i | input | 1 | Allow RSSI-low termination |
| rssi_low_i | input | 1 | Signal level below threshold |
| abort_i | input | 1 | Abort command |
| len_we_i | input | 1 | Host write strobe for the length register |
| len_wdata_i | input | LEN_W | Host write data for the length register |
| len_o | output | LEN_W | Length register contents |
| wr_en_o | output | 1 | Buffer write enable |
| wr_addr_o | output | LEN_W | Buffer write address |
| wr_data_o | output | 8 | Buffer write data |
| busy_o | output | 1 | Hunting or receiving |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| crc_ok_o | output | 1 | CRC matched |
| rssi_abort_o | output | 1 | Frame ended on RSSI drop |
| cmd_abort_o | output | 1 | Frame ended on abort command |

## Verification
The bench walks frames through every CRC width and the no-CRC case. It then targets the cases where the end of the frame moves, and a design that got those wrong would do one of these:
- sample a stale length, writing too few or too many bytes when the length is raised mid-packet;
- keep waiting for bytes that will never come when the length is lowered below the octets already received;
- swallow the first CRC bit after a zero-length payload.

Early exits are run with RSSI termination on and off, and with an abort and an RSSI drop in the same cycle. These catch a design that reports the host's length instead of the octets received, or that sets the wrong cause bit. A near-miss sync pattern checks that no payload is written without a genuine match. A single flipped CRC bit must clear the match status.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_DATA, ST_FCS} rx_state_e;

  function automatic logic [31:0] fcs_poly(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'h0000_0007;
      2'd1:    return 32'h0000_1021;
      2'd2:    return 32'h0086_4CFB;
      default: return 32'h04C1_1DB7;
    endcase
  endfunction

  function automatic logic [31:0] fcs_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      2'd2:    return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [5:0] fcs_bits(input logic [1:0] sel);
    return {1'b0, sel, 3'b000} + 6'd8;
  endfunction
endpackage

// File: rtl/rxd_sync.sv
module rxd_sync #(
  parameter int SYNC_W = 24,
  parameter int ERRS   = 0,
  localparam int CW    = $clog2(SYNC_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              vld_i,
  input  logic              bit_i,
  input  logic [SYNC_W-1:0] word_i,
  output logic              hit_o
);
  logic [SYNC_W-1:0] sr_q, sr_n;
  logic [CW-1:0]     fill_q, errs;

  always_comb begin
    sr_n = {sr_q[SYNC_W-2:0], bit_i};
    errs = '0;
    for (int i = 0; i < SYNC_W; i++) errs = errs + CW'(sr_n[i] ^ word_i[i]);
  end

  // combinational so the first payload bit may follow the last sync bit directly
  assign hit_o = vld_i && !clear_i && (fill_q >= CW'(SYNC_W - 1)) && (errs <= CW'(ERRS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else if (clear_i) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else if (vld_i) begin
      sr_q <= sr_n;
      if (fill_q != CW'(SYNC_W)) fill_q <= fill_q + 1'b1;
    end
  end

  AST_FILL_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (fill_q == '0)); // R1
endmodule

// File: rtl/rxd_crc.sv
module rxd_crc
  import rxd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic        bit_i,
  input  logic [1:0]  sel_i,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q, mask, nxt;
  logic [5:0]  top;
  logic        fb;

  always_comb begin
    mask = fcs_mask(sel_i);
    top  = fcs_bits(sel_i) - 6'd1;
    fb   = bit_i ^ crc_q[top[4:0]];
    nxt  = ((crc_q << 1) ^ (fb ? fcs_poly(sel_i) : 32'd0)) & mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (init_i) crc_q <= mask;
    else if (en_i)   crc_q <= nxt;
  end

  assign crc_o = crc_q;

  AST_CRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !en_i) |=> $stable(crc_o)); // R4
endmodule

// File: rtl/raw_rx_deframer.sv
module raw_rx_deframer
  import rxd_pkg::*;
#(
  parameter int LEN_W     = 9,
  parameter int SYNC_W    = 24,
  parameter int SYNC_ERRS = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  input  logic [SYNC_W-1:0] sync_word_i,
  input  logic              crc_en_i,
  input  logic [1:0]        crc_sel_i,
  input  logic              rssi_en_i,
  input  logic              rssi_low_i,
  input  logic              abort_i,
  input  logic              len_we_i,
  input  logic [LEN_W-1:0]  len_wdata_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              wr_en_o,
  output logic [LEN_W-1:0]  wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              crc_ok_o,
  output logic              rssi_abort_o,
  output logic              cmd_abort_o
);
  rx_state_e        state_q;
  logic [LEN_W-1:0] len_q, byte_cnt_q, cnt_inc;
  logic [2:0]       bit_cnt_q;
  logic [7:0]       byte_sr_q, byte_nxt;
  logic [4:0]       fcs_cnt_q;
  logic [31:0]      fcs_rx_q, fcs_full, crc_val;
  logic             sync_hit, rssi_cut, len_reached, fcs_last, crc_init, crc_step;

  rxd_sync #(.SYNC_W(SYNC_W), .ERRS(SYNC_ERRS)) u_sync (
    .clk_i, .rst_ni,
    .clear_i (state_q != ST_HUNT),
    .vld_i   (bit_vld_i),
    .bit_i,
    .word_i  (sync_word_i),
    .hit_o   (sync_hit)
  );

  always_comb begin
    rssi_cut    = rssi_en_i && rssi_low_i;
    len_reached = byte_cnt_q >= len_q;
    cnt_inc     = byte_cnt_q + 1'b1;
    byte_nxt    = {bit_i, byte_sr_q[7:1]};
    fcs_full    = fcs_rx_q | ({31'd0, bit_i} << fcs_cnt_q);
    fcs_last    = {1'b0, fcs_cnt_q} == (fcs_bits(crc_sel_i) - 6'd1);
    crc_init    = (state_q == ST_HUNT) && sync_hit;
    crc_step    = (state_q == ST_DATA) && bit_vld_i && !abort_i && !rssi_cut && !len_reached;
  end

  rxd_crc u_crc (
    .clk_i, .rst_ni,
    .init_i (crc_init),
    .en_i   (crc_step),
    .bit_i,
    .sel_i  (crc_sel_i),
    .crc_o  (crc_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      len_q        <= '0;
      byte_cnt_q   <= '0;
      bit_cnt_q    <= '0;
      byte_sr_q    <= '0;
      fcs_cnt_q    <= '0;
      fcs_rx_q     <= '0;
      wr_en_o      <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      done_o       <= 1'b0;
      crc_ok_o     <= 1'b0;
      rssi_abort_o <= 1'b0;
      cmd_abort_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      done_o  <= 1'b0;
      if (len_we_i) len_q <= len_wdata_i;
      case (state_q)
        ST_IDLE: if (arm_i) begin
          state_q      <= ST_HUNT;
          crc_ok_o     <= 1'b0;
          rssi_abort_o <= 1'b0;
          cmd_abort_o  <= 1'b0;
        end
        ST_HUNT: begin
          if (abort_i) begin
            state_q     <= ST_IDLE;
            done_o      <= 1'b1;
            cmd_abort_o <= 1'b1;
            len_q       <= '0;
          end else if (sync_hit) begin
            byte_cnt_q <= '0;
            bit_cnt_q  <= '0;
            fcs_cnt_q  <= '0;
            fcs_rx_q   <= '0;
            if (len_q != '0)   state_q <= ST_DATA;
            else if (crc_en_i) state_q <= ST_FCS;
            else begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
              len_q   <= '0;
            end
          end
        end
        ST_DATA: begin
          if (abort_i || rssi_cut) begin
            state_q      <= ST_IDLE;
            done_o       <= 1'b1;
            cmd_abort_o  <= abort_i;
            rssi_abort_o <= !abort_i;
            len_q        <= byte_cnt_q;
          end else if (len_reached) begin
            // host lowered the length below what has arrived
            if (crc_en_i) state_q <= ST_FCS;
            else begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
              len_q   <= byte_cnt_q;
            end
          end else if (bit_vld_i) begin
            byte_sr_q <= byte_nxt;
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) begin
              wr_en_o    <= 1'b1;
              wr_addr_o  <= byte_cnt_q;
              wr_data_o  <= byte_nxt;
              byte_cnt_q <= cnt_inc;
              if (cnt_inc >= len_q) begin
                if (crc_en_i) state_q <= ST_FCS;
                else begin
                  state_q <= ST_IDLE;
                  done_o  <= 1'b1;
                  len_q   <= cnt_inc;
                end
              end
            end
          end
        end
        ST_FCS: begin
          if (abort_i || rssi_cut) begin
            state_q      <= ST_IDLE;
            done_o       <= 1'b1;
            cmd_abort_o  <= abort_i;
            rssi_abort_o <= !abort_i;
            len_q        <= byte_cnt_q;
          end else if (bit_vld_i) begin
            fcs_rx_q  <= fcs_full;
            fcs_cnt_q <= fcs_cnt_q + 5'd1;
            if (fcs_last) begin
              state_q  <= ST_IDLE;
              done_o   <= 1'b1;
              len_q    <= byte_cnt_q;
              crc_ok_o <= ((fcs_full & fcs_mask(crc_sel_i)) == crc_val);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = state_q != ST_IDLE;
  assign len_o  = len_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_ONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot0({crc_ok_o, rssi_abort_o, cmd_abort_o})); // R7
  AST_ABORT_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && busy_o) |=> (done_o && cmd_abort_o && !rssi_abort_o)); // R7
  AST_RSSI_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rssi_en_i && rssi_low_i && !abort_i && (state_q == ST_DATA || state_q == ST_FCS))
      |=> (done_o && rssi_abort_o)); // R6
endmodule

// File: tb/raw_rx_deframer_bench.sv
module raw_rx_deframer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] SYNC = 24'hB34F1D;
  localparam int NV = 5;
  // fields: [31:24] length, [23:16] crc enable, [15:8] crc select, [7:0] seed
  localparam logic [31:0] VEC [NV] = '{
    32'h03_01_00_11, 32'h01_01_01_A5, 32'h07_01_02_3C,
    32'h0C_01_03_E0, 32'h06_00_00_5A };

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 0, bit_d = 0, vld = 0, crc_en = 0, rssi_en = 0, rssi_low = 0;
  logic abort = 0, len_we = 0, rssi_hold = 0;
  logic [1:0] crc_sel = 0;
  logic [8:0] len_wdata = 0, len_o, wr_addr;
  logic [7:0] wr_data;
  logic wr_en, busy, done, crc_ok, rssi_ab, cmd_ab;
  logic [7:0] pl [64];
  logic [7:0] cap [64];
  int checks = 0, errors = 0, wr_cnt = 0, n_done = 0, addr_bad = 0;
  int wr_base, done_base, bad_base;

  always #(CLK_PERIOD/2) clk = ~clk;

  raw_rx_deframer u_raw_rx_deframer (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .bit_i(bit_d), .bit_vld_i(vld),
    .sync_word_i(SYNC), .crc_en_i(crc_en), .crc_sel_i(crc_sel), .rssi_en_i(rssi_en),
    .rssi_low_i(rssi_low), .abort_i(abort), .len_we_i(len_we), .len_wdata_i(len_wdata),
    .len_o(len_o), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .busy_o(busy), .done_o(done), .crc_ok_o(crc_ok), .rssi_abort_o(rssi_ab),
    .cmd_abort_o(cmd_ab));

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      if (int'(wr_addr) != wr_cnt - wr_base) addr_bad++;
      cap[wr_addr[5:0]] = wr_data;
      wr_cnt++;
    end
    if (done) n_done++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n, input logic [1:0] sel);
    logic [31:0] mask, poly, c;
    int w;
    w = 8 * (int'(sel) + 1);
    mask = (sel == 2'd3) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    poly = sel == 0 ? 32'h07 : sel == 1 ? 32'h1021 : sel == 2 ? 32'h864CFB : 32'h04C11DB7;
    c = mask;
    for (int b = 0; b < n; b++)
      for (int k = 0; k < 8; k++) begin
        logic fb;
        fb = pl[b][k] ^ c[w-1];
        c = (c << 1) & mask;
        if (fb) c = c ^ poly;
      end
    return c;
  endfunction

  task automatic send_bit(input logic b, input logic ab, input logic rs, input logic lw, input int lv);
    @(negedge clk);
    bit_d = b; vld = 1; abort = ab; rssi_low = rs | rssi_hold;
    len_we = lw; len_wdata = 9'(lv);
  endtask

  task automatic fill_payload(input logic [7:0] seed);
    for (int i = 0; i < 64; i++) pl[i] = (seed + 8'(i * 37)) ^ 8'(i);
  endtask

  // ev_kind: 0 none, 1 abort, 2 rssi drop, 3 both, 4 length write of ev_val
  task automatic run_frame(input int n, input logic ce, input logic [1:0] sel, input int len0,
                           input logic [23:0] sw, input int ev_byte, input int ev_bit,
                           input int ev_kind, input int ev_val, input logic [31:0] flip);
    logic [31:0] c;
    wr_base = wr_cnt; done_base = n_done; bad_base = addr_bad;
    @(negedge clk); len_we = 1; len_wdata = 9'(len0);
    @(negedge clk); len_we = 0; arm = 1; crc_en = ce; crc_sel = sel;
    @(negedge clk); arm = 0;
    for (int i = 0; i < 16; i++) send_bit(i[0], 0, 0, 0, 0);
    for (int i = 23; i >= 0; i--) send_bit(sw[i], 0, 0, 0, 0);
    for (int b = 0; b < n; b++)
      for (int k = 0; k < 8; k++) begin
        bit ev;
        ev = (b == ev_byte) && (k == ev_bit);
        send_bit(pl[b][k], ev && (ev_kind == 1 || ev_kind == 3),
                 ev && (ev_kind == 2 || ev_kind == 3), ev && ev_kind == 4, ev_val);
      end
    if (ce) begin
      c = ref_crc(n, sel) ^ flip;
      for (int k = 0; k < 8 * (int'(sel) + 1); k++) send_bit(c[k], 0, 0, 0, 0);
    end
    @(negedge clk); vld = 0; abort = 0; rssi_low = rssi_hold; len_we = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frame(input string req, input int exp_len, input logic exp_ok,
                             input logic exp_rs, input logic exp_cmd);
    int bad;
    bad = 0;
    for (int i = 0; i < exp_len; i++) if (cap[i] !== pl[i]) bad++;
    chk(int'(len_o) == exp_len, {req, " R8 length"}, int'(len_o), exp_len);
    chk(wr_cnt - wr_base == exp_len, {req, " R3 bytes written"}, wr_cnt - wr_base, exp_len);
    chk(bad == 0, {req, " R2 byte data"}, bad, 0);
    chk(addr_bad == bad_base, {req, " R2 address order"}, addr_bad - bad_base, 0);
    chk(n_done - done_base == 1, {req, " R9 single done"}, n_done - done_base, 1);
    chk(crc_ok == exp_ok, {req, " R4 crc status"}, int'(crc_ok), int'(exp_ok));
    chk(rssi_ab == exp_rs, {req, " R6 rssi status"}, int'(rssi_ab), int'(exp_rs));
    chk(cmd_ab == exp_cmd, {req, " R7 abort status"}, int'(cmd_ab), int'(exp_cmd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!done && !wr_en && !busy, "R9 reset outputs", int'({done, wr_en, busy}), 0);
    chk(len_o == 0 && !crc_ok && !rssi_ab && !cmd_ab, "R9 reset status", int'(len_o), 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      fill_payload(VEC[v][7:0]);
      run_frame(int'(VEC[v][31:24]), VEC[v][16], VEC[v][9:8], int'(VEC[v][31:24]),
                SYNC, -1, 0, 0, 0, 32'd0);
      check_frame($sformatf("R1 R4 R5 vec%0d", v), int'(VEC[v][31:24]), VEC[v][16], 0, 0);
      chk(!done, "R9 done is a pulse", int'(done), 0);
    end

    // R5 corrupted CRC
    fill_payload(8'h77);
    run_frame(4, 1, 2'd2, 4, SYNC, -1, 0, 0, 0, 32'h20);
    check_frame("R5 crc mismatch", 4, 0, 0, 0);

    // R3 length raised mid-frame
    fill_payload(8'h42);
    run_frame(5, 1, 2'd1, 2, SYNC, 1, 0, 4, 5, 32'd0);
    check_frame("R3 length raised", 5, 1, 0, 0);

    // R11 length lowered below received count
    fill_payload(8'h99);
    run_frame(8, 0, 2'd0, 8, SYNC, 4, 0, 4, 2, 32'd0);
    check_frame("R11 length lowered", 4, 0, 0, 0);

    // R10 zero-length payload with 2-octet CRC
    fill_payload(8'h00);
    run_frame(0, 1, 2'd1, 0, SYNC, -1, 0, 0, 0, 32'd0);
    check_frame("R10 zero length", 0, 1, 0, 0);

    // R6 RSSI drop ignored when disabled
    rssi_en = 0; rssi_hold = 1;
    fill_payload(8'h1F);
    run_frame(4, 1, 2'd0, 4, SYNC, -1, 0, 0, 0, 32'd0);
    check_frame("R6 rssi ignored", 4, 1, 0, 0);
    rssi_hold = 0; rssi_low = 0;

    // R6 RSSI drop ends the frame
    rssi_en = 1;
    fill_payload(8'hC4);
    run_frame(6, 1, 2'd3, 6, SYNC, 2, 3, 2, 0, 32'd0);
    check_frame("R6 rssi cut", 2, 0, 1, 0);

    // R7 abort and RSSI in the same cycle
    fill_payload(8'h6B);
    run_frame(6, 1, 2'd0, 6, SYNC, 2, 3, 3, 0, 32'd0);
    check_frame("R7 abort priority", 2, 0, 0, 1);
    rssi_en = 0;

    // R1 near-miss sync word starts nothing
    fill_payload(8'h33);
    run_frame(3, 0, 2'd0, 3, SYNC ^ 24'h000100, -1, 0, 0, 0, 32'd0);
    chk(wr_cnt == wr_base, "R1 no bytes without sync", wr_cnt - wr_base, 0);
    chk(busy && n_done == done_base, "R1 still hunting", int'(busy), 1);

    // R7 abort while hunting
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
    chk(done && cmd_ab && !rssi_ab && !crc_ok, "R7 abort in hunt", int'({done, cmd_ab}), 3);
    chk(len_o == 0, "R8 length after hunt abort", int'(len_o), 0);
    repeat (2) @(negedge clk);
    chk(cmd_ab && !done, "R9 status held", int'({cmd_ab, done}), 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule